// File: doc/BRIEF.md
# Command-Driven Flash Controller Front End

This block interprets bus writes as command codes for a small nonvolatile array, modelled here in on-chip memory. A bus read returns one of three things, chosen by the current read mode: array words, the status byte, or the lock bit of the block that holds the addressed location. The mode is set by the last command accepted. A page program command is followed by a load phase, in which one full page of 16-bit words is written in strict address order. An automatic write then copies the loaded page into the array. While the copy runs the controller is busy, its reads show the status byte, and it ignores further commands.

Protection is checked when the load phase ends. If the target page lies in a locked block, or has been programmed before, the array is left untouched and a sticky program-error bit is set. A write out of order during the load phase has the same effect and ends the command. A separate reset bit input returns the controller to array reads at any time, and also cuts short a running auto-write.

Top module: `flc_frontend`

## Requirements
- R1: After `rst`, reads return array words, `ready` is 1 and the status byte is 0x80. Every array word starts as 0xFFFF.
- R2: A write of command 0xFF (data bits 7:0) selects array reads. A read then returns the word at byte address `bus_addr` with bit 0 ignored. Read data appears on `bus_rdata` one cycle after `bus_rd` and is held until the next read.
- R3: Command 0x70 selects status reads, which return {8'h00, status}. The status bits are: bit 7 ready, bit 4 program error, bits 6, 5, 3, 2, 1 and 0 zero.
- R4: Command 0x50 clears status bits 5 to 3 and leaves the read mode unchanged.
- R5: Command 0x71 selects lock reads, which return 1 in bit 0 when the addressed block is locked and 0 otherwise. By default, block 2 (byte addresses 0x400 to 0x5FF) is locked.
- R6: Command 0x41 is followed by 128 data writes to one 256-byte page, at offsets 0x00, 0x02 and so on up to 0xFE. Once the auto-write completes, array reads return the loaded words.
- R7: Command 0x41 switches reads to status. When the last data write is accepted, `ready` and status bit 7 fall to 0. They stay at 0 for exactly 129 + PROG_WAIT cycles and then both return to 1.
- R8: After a program, status reads persist through commands 0x70 and 0x50. They end only on 0xFF, on 0x71, or on the reset bit.
- R9: A program aimed at a locked block sets status bit 4, never drops `ready`, and leaves the array unchanged.
- R10: A program aimed at a page that has already been programmed sets status bit 4, never drops `ready`, and leaves the array unchanged.
- R11: During the load phase, a data write whose page or offset breaks the sequence sets status bit 4 and ends the command. The array is unchanged, and the next write is decoded as a command.
- R12: Command writes made while `ready` is 0 are ignored.
- R13: A pulse on `ctl_reset` returns the controller to idle with array reads and `ready` at 1 by the next cycle, from any state.
- R14: A read and a command write in the same cycle: the read is served in the mode that was in force before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_reset | input | 1 | Reset bit: abort and return to array reads |
| bus_wr | input | 1 | Write strobe (command or load data) |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 16 | Write data; command code in bits 7:0 |
| bus_rdata | output | 16 | Read data, one cycle after `bus_rd` |
| ready | output | 1 | 1 when no auto-write is running |

## Verification
Two functions can coincide in one cycle: a read, and the command write that changes the read mode. The bench raises `bus_rd` and a 0x70 write on the same clock edge while array reads are active. It expects the array word to be returned, and the following read to return the status byte. Two further cases are also driven into one cycle. In the first, a command write arrives while the auto-write is still running, and a later read must show that status reads remain in force. In the second, `ctl_reset` strikes during the copy, and `ready` and array reads must follow on the next edge.

// File: rtl/flc_pkg.sv
package flc_pkg;
  typedef enum logic [1:0] {MODE_ARRAY, MODE_STATUS, MODE_LOCK} rd_mode_e;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_COPY, ST_WAIT} fsm_e;

  localparam logic [7:0] CMD_RD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_RD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLR_STATUS = 8'h50;
  localparam logic [7:0] CMD_RD_LOCK    = 8'h71;
  localparam logic [7:0] CMD_PAGE_PROG  = 8'h41;
endpackage

// File: rtl/flc_page_buf.sv
module flc_page_buf #(
  parameter int DW    = 16,
  parameter int DEPTH = 128
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [DW-1:0]            wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [DW-1:0]            rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/flc_array.sv
module flc_array #(
  parameter int DW    = 16,
  parameter int WORDS = 1024
) (
  input  logic                     clk,
  input  logic                     rd_en,
  input  logic [$clog2(WORDS)-1:0] rd_idx,
  output logic [DW-1:0]            rd_data,
  input  logic                     we,
  input  logic [$clog2(WORDS)-1:0] w_idx,
  input  logic [DW-1:0]            w_data
);
  logic [DW-1:0] mem [WORDS];

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = {DW{1'b1}};
  end

  always_ff @(posedge clk) begin
    if (we) mem[w_idx] <= w_data;
    if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/flc_cmd_fsm.sv
module flc_cmd_fsm
  import flc_pkg::*;
#(
  parameter int PAGE_WORDS    = 128,
  parameter int OFF_W         = 7,
  parameter int NUM_PAGES     = 8,
  parameter int PAGE_W        = 3,
  parameter int PAGES_PER_BLK = 2,
  parameter int NUM_BLK       = 4,
  parameter int PROG_WAIT     = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctl_reset,
  input  logic               bus_wr,
  input  logic [7:0]         cmd,
  input  logic [PAGE_W-1:0]  wr_page,
  input  logic [OFF_W-1:0]   wr_off,
  input  logic [NUM_BLK-1:0] lock_v,
  output rd_mode_e           mode,
  output logic [7:0]         status,
  output logic               busy,
  output logic               buf_we,
  output logic [OFF_W-1:0]   buf_widx,
  output logic [OFF_W-1:0]   buf_ridx,
  output logic               arr_we,
  output logic [PAGE_W-1:0]  arr_page,
  output logic [OFF_W-1:0]   arr_off
);
  localparam int BLK_SH = $clog2(PAGES_PER_BLK);
  localparam int WCW    = $clog2(PROG_WAIT + 1);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_WORDS - 1);

  fsm_e                 state;
  logic [2:0]           sr_err;
  logic [OFF_W-1:0]     cnt;
  logic [PAGE_W-1:0]    page_r;
  logic [OFF_W:0]       copy_cnt;
  logic [WCW-1:0]       wcnt;
  logic [NUM_PAGES-1:0] done_pg;

  logic                 seq_ok;
  logic [PAGE_W-1:0]    tgt_page;
  logic [PAGE_W-1:0]    tgt_blk;
  logic                 blocked;

  assign seq_ok   = (wr_off == cnt) && ((cnt == '0) || (wr_page == page_r));
  assign tgt_page = (cnt == '0) ? wr_page : page_r;
  assign tgt_blk  = tgt_page >> BLK_SH;
  assign blocked  = lock_v[tgt_blk] || done_pg[tgt_page];

  assign busy     = (state == ST_COPY) || (state == ST_WAIT);
  assign status   = {~busy, 1'b0, sr_err, 3'b000};
  assign buf_we   = (state == ST_LOAD) && bus_wr && seq_ok && !ctl_reset;
  assign buf_widx = cnt;
  assign buf_ridx = copy_cnt[OFF_W-1:0];
  assign arr_we   = (state == ST_COPY) && (copy_cnt != '0) && !ctl_reset;
  assign arr_page = page_r;
  assign arr_off  = copy_cnt[OFF_W-1:0] - OFF_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mode     <= MODE_ARRAY;
      sr_err   <= '0;
      cnt      <= '0;
      page_r   <= '0;
      copy_cnt <= '0;
      wcnt     <= '0;
      done_pg  <= '0;
    end else if (ctl_reset) begin
      state    <= ST_IDLE;
      mode     <= MODE_ARRAY;
      cnt      <= '0;
      copy_cnt <= '0;
      wcnt     <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (bus_wr) begin
            case (cmd)
              CMD_RD_ARRAY:   mode <= MODE_ARRAY;
              CMD_RD_STATUS:  mode <= MODE_STATUS;
              CMD_RD_LOCK:    mode <= MODE_LOCK;
              CMD_CLR_STATUS: sr_err <= '0;
              CMD_PAGE_PROG: begin
                state <= ST_LOAD;
                mode  <= MODE_STATUS;
                cnt   <= '0;
              end
              default: ;
            endcase
          end
        end
        ST_LOAD: begin
          if (bus_wr) begin
            if (!seq_ok) begin
              sr_err[1] <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              if (cnt == '0) page_r <= wr_page;
              cnt <= cnt + OFF_W'(1);
              if (cnt == LAST_OFF) begin
                if (blocked) begin
                  sr_err[1] <= 1'b1;
                  state     <= ST_IDLE;
                end else begin
                  state    <= ST_COPY;
                  copy_cnt <= '0;
                end
              end
            end
          end
        end
        ST_COPY: begin
          copy_cnt <= copy_cnt + (OFF_W+1)'(1);
          if (copy_cnt == (OFF_W+1)'(PAGE_WORDS)) begin
            state <= ST_WAIT;
            wcnt  <= '0;
          end
        end
        ST_WAIT: begin
          wcnt <= wcnt + WCW'(1);
          if (wcnt == WCW'(PROG_WAIT - 1)) begin
            state           <= ST_IDLE;
            done_pg[page_r] <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_RESET_BIT_IDLE: assert property (@(posedge clk) disable iff (rst)
    ctl_reset |=> (!busy && mode == MODE_ARRAY)); // R13
  AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_wr && !ctl_reset) |=> (mode == MODE_STATUS && $stable(sr_err))); // R12
  AST_CLEAR_ERR: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && bus_wr && cmd == CMD_CLR_STATUS && !ctl_reset) |=> (sr_err == 3'b000)); // R4
  AST_BUSY_SHOWS_STATUS: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (mode == MODE_STATUS)); // R7
  AST_NO_REPROGRAM: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> !done_pg[arr_page]); // R10
endmodule

// File: rtl/flc_frontend.sv
module flc_frontend
  import flc_pkg::*;
#(
  parameter int          ADDR_W        = 11,
  parameter int          PAGE_BYTES    = 256,
  parameter int          PAGES_PER_BLK = 2,
  parameter int          PROG_WAIT     = 16,
  parameter logic [63:0] LOCK_INIT     = 64'h4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_reset,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              ready
);
  localparam int DW         = 16;
  localparam int BYTE_LSB   = $clog2(DW / 8);
  localparam int PAGE_WORDS = PAGE_BYTES / (DW / 8);
  localparam int OFF_W      = $clog2(PAGE_WORDS);
  localparam int PAGE_LSB   = $clog2(PAGE_BYTES);
  localparam int PAGE_W     = ADDR_W - PAGE_LSB;
  localparam int NUM_PAGES  = 1 << PAGE_W;
  localparam int WORD_W     = ADDR_W - BYTE_LSB;
  localparam int NUM_WORDS  = 1 << WORD_W;
  localparam int NUM_BLK    = NUM_PAGES / PAGES_PER_BLK;
  localparam int BLK_SH     = $clog2(PAGES_PER_BLK);

  logic [NUM_BLK-1:0] lock_v;
  rd_mode_e           mode;
  logic [7:0]         status;
  logic               busy;
  logic               buf_we;
  logic [OFF_W-1:0]   buf_widx;
  logic [OFF_W-1:0]   buf_ridx;
  logic [DW-1:0]      buf_q;
  logic               arr_we;
  logic [PAGE_W-1:0]  arr_page;
  logic [OFF_W-1:0]   arr_off;
  logic [DW-1:0]      arr_q;
  logic [PAGE_W-1:0]  rd_page;
  logic [PAGE_W-1:0]  rd_blk;
  rd_mode_e           sel_q;
  logic [DW-1:0]      aux_q;
  logic               unused_lsb;

  assign lock_v     = LOCK_INIT[NUM_BLK-1:0];
  assign unused_lsb = ^bus_addr[BYTE_LSB-1:0];
  assign rd_page    = bus_addr[ADDR_W-1:PAGE_LSB];
  assign rd_blk     = rd_page >> BLK_SH;

  flc_cmd_fsm #(
    .PAGE_WORDS(PAGE_WORDS), .OFF_W(OFF_W), .NUM_PAGES(NUM_PAGES), .PAGE_W(PAGE_W),
    .PAGES_PER_BLK(PAGES_PER_BLK), .NUM_BLK(NUM_BLK), .PROG_WAIT(PROG_WAIT)
  ) fsm_i (
    .clk(clk), .rst(rst), .ctl_reset(ctl_reset), .bus_wr(bus_wr),
    .cmd(bus_wdata[7:0]), .wr_page(bus_addr[ADDR_W-1:PAGE_LSB]),
    .wr_off(bus_addr[PAGE_LSB-1:BYTE_LSB]), .lock_v(lock_v),
    .mode(mode), .status(status), .busy(busy),
    .buf_we(buf_we), .buf_widx(buf_widx), .buf_ridx(buf_ridx),
    .arr_we(arr_we), .arr_page(arr_page), .arr_off(arr_off)
  );

  flc_page_buf #(.DW(DW), .DEPTH(PAGE_WORDS)) buf_i (
    .clk(clk), .wr_en(buf_we), .wr_idx(buf_widx), .wr_data(bus_wdata),
    .rd_idx(buf_ridx), .rd_data(buf_q)
  );

  flc_array #(.DW(DW), .WORDS(NUM_WORDS)) arr_i (
    .clk(clk), .rd_en(bus_rd), .rd_idx(bus_addr[ADDR_W-1:BYTE_LSB]), .rd_data(arr_q),
    .we(arr_we), .w_idx({arr_page, arr_off}), .w_data(buf_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= MODE_ARRAY;
      aux_q <= '0;
    end else if (bus_rd) begin
      sel_q <= mode;
      aux_q <= (mode == MODE_LOCK) ? {{(DW-1){1'b0}}, lock_v[rd_blk]} : {8'h00, status};
    end
  end

  assign bus_rdata = (sel_q == MODE_ARRAY) ? arr_q : aux_q;
  assign ready     = ~busy;

  AST_NO_LOCKED_WRITE: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> !lock_v[arr_page >> BLK_SH]); // R9
  AST_READY_MATCHES_SR7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && mode == MODE_STATUS) |=> (bus_rdata[7] == $past(ready))); // R7
endmodule

// File: tb/flc_frontend_tb_top.sv
`timescale 1ns/1ps
module flc_frontend_tb_top;
  localparam int PROG_WAIT = 16;
  localparam int BUSY_LEN  = 129 + PROG_WAIT;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_reset = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ready;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  flc_frontend #(.PROG_WAIT(PROG_WAIT)) dut_i (
    .clk(clk), .rst(rst), .ctl_reset(ctl_reset), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ready(ready)
  );

  typedef struct packed {
    logic        is_rd;
    logic [10:0] addr;
    logic [15:0] data;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 11'h000, 16'hFFFF},  // R1/R2 array reads after reset
    '{1'b1, 11'h007, 16'hFFFF},  // R2 odd address
    '{1'b0, 11'h000, 16'h0070},
    '{1'b1, 11'h000, 16'h0080},  // R3 status
    '{1'b0, 11'h000, 16'h0071},
    '{1'b1, 11'h000, 16'h0000},  // R5 unlocked block 0
    '{1'b1, 11'h402, 16'h0001},  // R5 locked block 2
    '{1'b1, 11'h600, 16'h0000},  // R5 unlocked block 3
    '{1'b0, 11'h000, 16'h00FF},
    '{1'b1, 11'h1FE, 16'hFFFF}   // R2 back to array
  };

  function automatic logic [15:0] pat(input int page, input int k);
    return 16'((page << 12) ^ (k * 3) ^ 16'h0A50);
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [15:0] q);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    q = bus_rdata;
  endtask

  task automatic load_page(input int page);
    wr(11'h000, 16'h0041);
    for (int k = 0; k < 128; k++) wr(11'(page * 256 + 2 * k), pat(page, k));
  endtask

  task automatic count_busy(output int n);
    n = 0;
    for (int i = 0; i < 400; i++) begin
      if (!ready) n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #750000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] q;
    int nb;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", {15'b0, ready}, 16'h0001);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_rd) begin
        rd(VEC[i].addr, q);
        chk($sformatf("R2/R3/R5 vector %0d", i), q, VEC[i].data);
      end else begin
        wr(VEC[i].addr, VEC[i].data);
      end
    end

    // Program page 0, poke during busy
    load_page(0);
    rd(11'h000, q);
    chk("R7 status during auto-write", q, 16'h0000);
    wr(11'h000, 16'h00FF);   // R12 ignored while busy
    for (int i = 0; i < 400 && !ready; i++) @(negedge clk);
    chk("R7 ready back", {15'b0, ready}, 16'h0001);
    rd(11'h000, q);
    chk("R12 command while busy ignored", q, 16'h0080);
    wr(11'h000, 16'h0070);
    rd(11'h000, q);
    chk("R8 status kept after 0x70", q, 16'h0080);
    wr(11'h000, 16'h0050);
    rd(11'h000, q);
    chk("R8 status kept after 0x50", q, 16'h0080);
    wr(11'h000, 16'h00FF);
    rd(11'h000, q);
    chk("R6 page0 word0", q, pat(0, 0));
    rd(11'h00B, q);
    chk("R6 page0 word5", q, pat(0, 5));
    rd(11'h0FE, q);
    chk("R6 page0 word127", q, pat(0, 127));

    // R14: read and command write in one cycle
    @(negedge clk);
    bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 11'h002; bus_wdata = 16'h0070;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    chk("R14 read uses old mode", bus_rdata, pat(0, 1));
    rd(11'h002, q);
    chk("R14 next read uses new mode", q, 16'h0080);

    // R10: reprogram page 0
    load_page(0);
    count_busy(nb);
    chk("R10 no busy on reprogram", 16'(nb), 16'h0000);
    rd(11'h000, q);
    chk("R10 program error set", q, 16'h0090);
    wr(11'h000, 16'h00FF);
    rd(11'h006, q);
    chk("R10 array unchanged", q, pat(0, 3));

    // R4: clear status
    wr(11'h000, 16'h0070);
    wr(11'h000, 16'h0050);
    rd(11'h000, q);
    chk("R4 error cleared", q, 16'h0080);
    rd(11'h000, q);
    chk("R4 mode unchanged", q, 16'h0080);

    // R9: locked block
    load_page(4);
    count_busy(nb);
    chk("R9 no busy on locked", 16'(nb), 16'h0000);
    rd(11'h000, q);
    chk("R9 program error set", q, 16'h0090);
    wr(11'h000, 16'h00FF);
    rd(11'h404, q);
    chk("R9 array unchanged", q, 16'hFFFF);
    wr(11'h000, 16'h0050);

    // R7 busy length on page 1
    load_page(1);
    count_busy(nb);
    chk("R7 busy cycle count", 16'(nb), 16'(BUSY_LEN));
    rd(11'h000, q);
    chk("R7 status after done", q, 16'h0080);
    wr(11'h000, 16'h0071);
    rd(11'h402, q);
    chk("R8 0x71 leaves status", q, 16'h0001);
    wr(11'h000, 16'h00FF);
    rd(11'h1FE, q);
    chk("R6 page1 word127", q, pat(1, 127));

    // R11: out-of-sequence abort
    wr(11'h000, 16'h0041);
    wr(11'h200, 16'h1234);
    wr(11'h204, 16'h5678);
    rd(11'h000, q);
    chk("R11 abort sets error", q, 16'h0090);
    wr(11'h000, 16'h00FF);
    rd(11'h200, q);
    chk("R11 next write is command, array unchanged", q, 16'hFFFF);
    wr(11'h000, 16'h0050);

    // R13: reset bit during copy
    load_page(3);
    repeat (3) @(negedge clk);
    chk("R13 busy before reset bit", {15'b0, ready}, 16'h0000);
    ctl_reset = 1'b1;
    @(negedge clk);
    ctl_reset = 1'b0;
    chk("R13 ready after reset bit", {15'b0, ready}, 16'h0001);
    rd(11'h000, q);
    chk("R13 array mode after reset bit", q, pat(0, 0));

    done = 1'b1;
    summary();
    $finish;
  end
endmodule